// File: doc/BRIEF.md
# Free-List Packet Receive Controller

This block sits between a network MAC's receive word stream and a large packet buffer memory made of fixed 8 KByte blocks. Before traffic starts, the host loads block numbers into a free-block queue. When a packet begins, the controller takes the oldest block number from that queue. It writes the packet's 32-bit words into consecutive words of that block and counts the bytes received.

At the end of the packet it posts one completion entry into a ready queue for the host. The entry packs the block number and the byte count into a single 32-bit word, with a separate per-packet overflow bit beside it. Because the whole result is one word, the host can take it in a single atomic read. The host is interrupted only when the ready queue goes from empty to holding an entry. The interrupt then stays up until the host acknowledges it, so a burst of packets costs the host one interrupt.

If no free block is available when a packet starts, the packet is thrown away and a drop counter advances. A packet longer than one block is cut at the block boundary and flagged. If the ready queue is full when a packet ends, the controller holds off the MAC stream until the host removes an entry.

Top module: `pkt_rx_freelist`

## Requirements
- R1: After reset the ready queue is empty, `irq` is 0, `drop_count` is 0, `mac_ready` is 1 and `mem_we` is 0.
- R2: At a start-of-packet word the controller takes the block numbers in the order the host pushed them. Word k of the packet (k counted from 0) is written with unchanged data to word address blk*2048 + k, so bits [29:11] of `mem_addr` hold the block and bits [10:0] hold k.
- R3: Each stored packet produces one completion. Bits [31:13] of `rdy_word` hold the block number and bits [12:0] hold the byte count. Every word except the last counts 4 bytes. The last word counts `mac_last_bytes` bytes, where code 0 means 4 and codes 1 to 3 mean that many bytes. Completions leave in packet order, and `rdy_ovf` is 0 for a packet that fits in its block.
- R4: A packet whose start word arrives while the free queue is empty writes nothing and posts no completion. The MAC stream is still accepted, and `drop_count` rises by 1 when the packet's end word is accepted.
- R5: A packet longer than 2048 words has only its first 2048 words written. Its completion carries `rdy_ovf` = 1, and its byte field holds the stored byte count modulo 8192, so a completely filled block reads 0.
- R6: `irq` rises one cycle after a completion enters an empty ready queue. It stays 1 until `irq_ack`, and a completion entering a non-empty queue does not raise it again.
- R7: A packet that ends while the ready queue is full drives `mac_ready` to 0. `mac_ready` returns to 1 once the host pops an entry, and the held completion is then queued without any completion being lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| free_push | input | 1 | Host pushes a free block number |
| free_blk | input | 19 | Free block number being pushed |
| free_full | output | 1 | Free queue holds 256 entries |
| mac_valid | input | 1 | MAC word valid |
| mac_sop | input | 1 | Word is the first of a packet |
| mac_eop | input | 1 | Word is the last of a packet |
| mac_last_bytes | input | 2 | Valid bytes in the end word, 0 means 4 |
| mac_data | input | 32 | MAC data word |
| mac_ready | output | 1 | Controller accepts the MAC word this cycle |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | 30 | Buffer memory word address |
| mem_wdata | output | 32 | Buffer memory write data |
| rdy_pop | input | 1 | Host removes the head completion |
| rdy_word | output | 32 | Head completion: block and byte count |
| rdy_ovf | output | 1 | Head completion was truncated |
| rdy_empty | output | 1 | Ready queue holds no entry |
| irq | output | 1 | Host interrupt |
| irq_ack | input | 1 | Host clears the interrupt |
| drop_count | output | 16 | Packets discarded for lack of a free block |

## Verification
The assertions assume the MAC stream is well formed: every packet opens with a start word and closes with an end word, and no word arrives outside a packet. They also assume the host never pushes into a full free queue. The bench drives packets only through a task that always marks the first and last words, and it never pushes more block numbers than the free queue can hold. It keeps the packet stream idle while the host pops or acknowledges, so every write, completion and interrupt edge can be tied to one known packet.

// File: rtl/pkt_rx_pkg.sv
// Shared defaults for the free-list packet receive controller.
// Assumes 8-bit bytes and a power-of-two block size and queue depth.
package pkt_rx_pkg;
    localparam int DEF_BLK_W  = 19;   // block number width
    localparam int DEF_LEN_W  = 13;   // byte-count field width (block = 2**LEN_W bytes)
    localparam int DEF_DATA_W = 32;   // MAC and memory word width
    localparam int DEF_DEPTH  = 256;  // depth of both host queues
    localparam int DEF_CNT_W  = 16;   // drop counter width
endpackage

// File: rtl/pkt_rx_fifo.sv
// Show-ahead synchronous queue used for both host queues.
// The head entry is visible on dout while not empty. A push when full or a
// pop when empty is ignored. Assumes DEPTH is a power of two.
module pkt_rx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/pkt_rx_writer.sv
// Packet writer: claims a free block at start of packet, writes words into
// it, counts bytes, truncates at the block end, drops packets with no free
// block, and holds one completion until the ready queue has room (stalling
// the MAC stream meanwhile). Assumes a well-formed stream: every packet
// opens with mac_sop and closes with mac_eop.
module pkt_rx_writer #(
    parameter int BLK_W  = pkt_rx_pkg::DEF_BLK_W,
    parameter int LEN_W  = pkt_rx_pkg::DEF_LEN_W,
    parameter int DATA_W = pkt_rx_pkg::DEF_DATA_W,
    parameter int CNT_W  = pkt_rx_pkg::DEF_CNT_W,
    localparam int BPW    = DATA_W / 8,
    localparam int LB_W   = $clog2(BPW),
    localparam int WORDS  = (1 << LEN_W) / BPW,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int ADDR_W = BLK_W + WIDX_W,
    localparam int CPL_W  = 1 + BLK_W + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_valid,
    input  logic              mac_sop,
    input  logic              mac_eop,
    input  logic [LB_W-1:0]   mac_last_bytes,
    input  logic [DATA_W-1:0] mac_data,
    output logic              mac_ready,
    input  logic [BLK_W-1:0]  free_head,
    input  logic              free_empty,
    output logic              free_pop,
    input  logic              rdy_full,
    output logic              rdy_push,
    output logic [CPL_W-1:0]  rdy_din,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [CNT_W-1:0]  drop_count
);
    logic [BLK_W-1:0]  blk_q, cur_blk;
    logic [WIDX_W:0]   widx_q, cur_idx;
    logic [LEN_W:0]    len_q, base_len, len_nx, nb;
    logic              ovf_q, ovf_nx, drop_q, drop_now;
    logic              pend_q, acc, room, wr_now;
    logic [CPL_W-1:0]  pend_word;

    // Per-word decode: which block, which word, and whether it is stored.
    always_comb begin
        acc      = mac_valid && mac_ready;
        cur_blk  = mac_sop ? free_head : blk_q;
        cur_idx  = mac_sop ? '0 : widx_q;
        drop_now = mac_sop ? free_empty : drop_q;
        base_len = mac_sop ? '0 : len_q;
        room     = cur_idx < (WIDX_W + 1)'(WORDS);
        nb       = (mac_eop && mac_last_bytes != '0) ? (LEN_W + 1)'(mac_last_bytes)
                                                     : (LEN_W + 1)'(BPW);
        wr_now   = acc && !drop_now && room;
        len_nx   = wr_now ? base_len + nb : base_len;
        ovf_nx   = (mac_sop ? 1'b0 : ovf_q) | (acc && !drop_now && !room);
    end

    assign free_pop  = acc && mac_sop && !free_empty;
    assign rdy_push  = pend_q && !rdy_full;
    assign rdy_din   = pend_word;
    assign mac_ready = !(pend_q && rdy_full);

    // Packet state, byte count, truncation and drop bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q      <= '0;
            widx_q     <= '0;
            len_q      <= '0;
            ovf_q      <= 1'b0;
            drop_q     <= 1'b0;
            drop_count <= '0;
        end else if (acc) begin
            blk_q  <= cur_blk;
            widx_q <= wr_now ? cur_idx + 1'b1 : cur_idx;
            len_q  <= len_nx;
            ovf_q  <= ovf_nx;
            drop_q <= drop_now;
            if (mac_eop && drop_now) drop_count <= drop_count + 1'b1;
        end
    end

    // Registered memory write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= wr_now;
            mem_addr  <= {cur_blk, cur_idx[WIDX_W-1:0]};
            mem_wdata <= mac_data;
        end
    end

    // One-entry completion holder in front of the ready queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_word <= '0;
        end else if (acc && mac_eop && !drop_now) begin
            pend_q    <= 1'b1;
            pend_word <= {ovf_nx, cur_blk, len_nx[LEN_W-1:0]};
        end else if (rdy_push) begin
            pend_q    <= 1'b0;
        end
    end

    // R4: words that belong to a dropped packet never reach memory.
    a_r4_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q && mac_valid && mac_ready && !mac_sop) |=> !mem_we);
    // R5: once a block has overflowed, later words of the packet are not written.
    a_r5_trunc_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && mac_valid && mac_ready && !mac_sop) |=> !mem_we);
    // R7: a held completion is kept while the ready queue is full.
    a_r7_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && rdy_full) |=> pend_q);
endmodule

// File: rtl/pkt_rx_freelist.sv
// Top of the free-list packet receive controller: the host free-block queue,
// the packet writer, the ready completion queue and the host interrupt.
// The interrupt is set when a completion enters an empty ready queue and
// held until irq_ack; a set in the same cycle as an ack wins.
module pkt_rx_freelist #(
    parameter int BLK_W  = pkt_rx_pkg::DEF_BLK_W,
    parameter int LEN_W  = pkt_rx_pkg::DEF_LEN_W,
    parameter int DATA_W = pkt_rx_pkg::DEF_DATA_W,
    parameter int DEPTH  = pkt_rx_pkg::DEF_DEPTH,
    parameter int CNT_W  = pkt_rx_pkg::DEF_CNT_W,
    localparam int LB_W   = $clog2(DATA_W / 8),
    localparam int ADDR_W = BLK_W + $clog2((1 << LEN_W) / (DATA_W / 8)),
    localparam int CPL_W  = 1 + BLK_W + LEN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    free_push,
    input  logic [BLK_W-1:0]        free_blk,
    output logic                    free_full,
    input  logic                    mac_valid,
    input  logic                    mac_sop,
    input  logic                    mac_eop,
    input  logic [LB_W-1:0]         mac_last_bytes,
    input  logic [DATA_W-1:0]       mac_data,
    output logic                    mac_ready,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    rdy_pop,
    output logic [BLK_W+LEN_W-1:0]  rdy_word,
    output logic                    rdy_ovf,
    output logic                    rdy_empty,
    output logic                    irq,
    input  logic                    irq_ack,
    output logic [CNT_W-1:0]        drop_count
);
    logic [BLK_W-1:0] free_head;
    logic             free_empty, free_pop;
    logic             rdy_full, rdy_push;
    logic [CPL_W-1:0] rdy_din, rdy_dout;

    pkt_rx_fifo #(.W(BLK_W), .DEPTH(DEPTH)) u_free (
        .clk(clk), .rst_n(rst_n),
        .push(free_push), .din(free_blk),
        .pop(free_pop), .dout(free_head),
        .empty(free_empty), .full(free_full)
    );

    pkt_rx_writer #(.BLK_W(BLK_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .mac_valid(mac_valid), .mac_sop(mac_sop), .mac_eop(mac_eop),
        .mac_last_bytes(mac_last_bytes), .mac_data(mac_data), .mac_ready(mac_ready),
        .free_head(free_head), .free_empty(free_empty), .free_pop(free_pop),
        .rdy_full(rdy_full), .rdy_push(rdy_push), .rdy_din(rdy_din),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .drop_count(drop_count)
    );

    pkt_rx_fifo #(.W(CPL_W), .DEPTH(DEPTH)) u_rdy (
        .clk(clk), .rst_n(rst_n),
        .push(rdy_push), .din(rdy_din),
        .pop(rdy_pop), .dout(rdy_dout),
        .empty(rdy_empty), .full(rdy_full)
    );

    assign rdy_ovf  = rdy_dout[CPL_W-1];
    assign rdy_word = rdy_dout[CPL_W-2:0];

    // Interrupt: set on entry into an empty ready queue, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    irq <= 1'b0;
        else if (rdy_push && rdy_empty) irq <= 1'b1;
        else if (irq_ack)              irq <= 1'b0;
    end

    // R6: the interrupt only rises after the ready queue was empty.
    a_r6_rise_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rdy_empty));
    // R6: the interrupt is held until the host acknowledges it.
    a_r6_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
endmodule

// File: tb/pkt_rx_freelist_tb.sv
module pkt_rx_freelist_tb;
    localparam int BLK_W = 19;
    localparam int LEN_W = 13;
    localparam int WORDS = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        free_push = 1'b0;
    logic [18:0] free_blk = '0;
    logic        free_full;
    logic        mac_valid = 1'b0, mac_sop = 1'b0, mac_eop = 1'b0;
    logic [1:0]  mac_last_bytes = '0;
    logic [31:0] mac_data = '0;
    logic        mac_ready;
    logic        mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        rdy_pop = 1'b0;
    logic [31:0] rdy_word;
    logic        rdy_ovf, rdy_empty, irq;
    logic        irq_ack = 1'b0;
    logic [15:0] drop_count;

    int tests = 0;
    int fails = 0;
    logic [61:0] exp_wr [$];   // {addr, data}
    logic [32:0] exp_cpl [$];  // {ovf, block, length}

    always #2.5 clk = ~clk;   // 200 MHz

    pkt_rx_freelist u_dut (
        .clk(clk), .rst_n(rst_n),
        .free_push(free_push), .free_blk(free_blk), .free_full(free_full),
        .mac_valid(mac_valid), .mac_sop(mac_sop), .mac_eop(mac_eop),
        .mac_last_bytes(mac_last_bytes), .mac_data(mac_data), .mac_ready(mac_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rdy_pop(rdy_pop), .rdy_word(rdy_word), .rdy_ovf(rdy_ovf), .rdy_empty(rdy_empty),
        .irq(irq), .irq_ack(irq_ack), .drop_count(drop_count)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every memory write is compared with the next expected one (R2).
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_wr.size() == 0) begin
                chk(1'b0, "R2/R4/R5 unexpected write", {2'b0, mem_addr, mem_wdata}, 64'h0);
            end else begin
                logic [61:0] e;
                e = exp_wr.pop_front();
                chk({mem_addr, mem_wdata} == e, "R2 write addr/data", {2'b0, mem_addr, mem_wdata}, {2'b0, e});
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_free(input logic [18:0] b);
        @(negedge clk);
        free_push = 1'b1;
        free_blk  = b;
        @(negedge clk);
        free_push = 1'b0;
    endtask

    // Driver: sends one packet and records the expected writes and completion.
    task automatic send_pkt(input logic [18:0] blk, input int nwords, input logic [1:0] lastb,
                            input logic [15:0] id, input bit drop);
        int stored = 0;
        for (int i = 0; i < nwords; i++) begin
            logic seen;
            logic [31:0] d;
            d = {id, 16'(i)};
            if (!drop && i < WORDS) begin
                exp_wr.push_back({blk, 11'(i), d});
                stored += (i == nwords - 1 && lastb != 2'd0) ? int'(lastb) : 4;
            end
            @(negedge clk);
            mac_valid      = 1'b1;
            mac_sop        = (i == 0);
            mac_eop        = (i == nwords - 1);
            mac_last_bytes = lastb;
            mac_data       = d;
            forever begin
                seen = mac_ready;
                @(posedge clk);
                if (seen) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        mac_valid = 1'b0;
        mac_sop   = 1'b0;
        mac_eop   = 1'b0;
        if (!drop) exp_cpl.push_back({(nwords > WORDS), blk, 13'(stored)});
    endtask

    // Host side: pops n completions and compares each with the scoreboard (R3).
    task automatic drain(input int n);
        for (int k = 0; k < n; k++) begin
            logic [32:0] e;
            @(negedge clk);
            while (rdy_empty) @(negedge clk);
            e = exp_cpl.pop_front();
            chk(rdy_word == e[31:0], "R3 completion word", {32'b0, rdy_word}, {32'b0, e[31:0]});
            chk(rdy_ovf == e[32], "R3/R5 completion ovf", {63'b0, rdy_ovf}, {63'b0, e[32]});
            rdy_pop = 1'b1;
            @(negedge clk);
            rdy_pop = 1'b0;
        end
    endtask

    task automatic ack_irq();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rdy_empty == 1'b1, "R1 rdy_empty", {63'b0, rdy_empty}, 64'h1);
        chk(irq == 1'b0, "R1 irq", {63'b0, irq}, 64'h0);
        chk(drop_count == 16'd0, "R1 drop_count", {48'b0, drop_count}, 64'h0);
        chk(mac_ready == 1'b1, "R1 mac_ready", {63'b0, mac_ready}, 64'h1);
        chk(mem_we == 1'b0, "R1 mem_we", {63'b0, mem_we}, 64'h0);

        // R4: packets arriving with no free block are dropped
        send_pkt(19'd0, 3, 2'd0, 16'h00d1, 1'b1);
        send_pkt(19'd0, 1, 2'd1, 16'h00d2, 1'b1);
        cycles(3);
        chk(drop_count == 16'd2, "R4 drop_count", {48'b0, drop_count}, 64'h2);
        chk(rdy_empty == 1'b1, "R4 no completion", {63'b0, rdy_empty}, 64'h1);
        chk(irq == 1'b0, "R4 no irq", {63'b0, irq}, 64'h0);

        // R2/R3/R6: normal packets on blocks taken in push order
        push_free(19'd5);
        push_free(19'd9);
        push_free(19'h7abcd);
        send_pkt(19'd5, 3, 2'd2, 16'h0001, 1'b0);   // 10 bytes
        cycles(3);
        chk(irq == 1'b1, "R6 irq on empty->non-empty", {63'b0, irq}, 64'h1);
        send_pkt(19'd9, 1, 2'd0, 16'h0002, 1'b0);   // 4 bytes
        cycles(3);
        chk(irq == 1'b1, "R6 irq held without ack", {63'b0, irq}, 64'h1);
        ack_irq();
        cycles(1);
        chk(irq == 1'b0, "R6 irq cleared by ack", {63'b0, irq}, 64'h0);

        // R5: overlong packet truncated at the block end, field reads 0
        send_pkt(19'h7abcd, WORDS + 2, 2'd3, 16'h0003, 1'b0);
        cycles(3);
        chk(irq == 1'b0, "R6 no irq into non-empty queue", {63'b0, irq}, 64'h0);
        drain(3);
        cycles(2);
        chk(rdy_empty == 1'b1, "R3 queue drained", {63'b0, rdy_empty}, 64'h1);
        chk(drop_count == 16'd2, "R4 drop_count unchanged", {48'b0, drop_count}, 64'h2);

        // R6: interrupt re-arms after the queue has been empty
        push_free(19'd7);
        send_pkt(19'd7, 5, 2'd3, 16'h0004, 1'b0);   // 19 bytes
        cycles(3);
        chk(irq == 1'b1, "R6 irq re-raised after empty", {63'b0, irq}, 64'h1);
        ack_irq();
        drain(1);

        // R7: ready queue full at end of packet stalls the MAC
        for (int i = 0; i < 256; i++) push_free(19'(100 + i));
        for (int i = 0; i < 256; i++) send_pkt(19'(100 + i), 1, 2'd0, 16'(16'h0100 + i), 1'b0);
        push_free(19'd400);
        push_free(19'd401);
        send_pkt(19'd400, 1, 2'd2, 16'h0200, 1'b0);
        cycles(4);
        chk(mac_ready == 1'b0, "R7 stall while ready queue full", {63'b0, mac_ready}, 64'h0);
        drain(1);
        cycles(3);
        chk(mac_ready == 1'b1, "R7 resume after pop", {63'b0, mac_ready}, 64'h1);
        send_pkt(19'd401, 2, 2'd1, 16'h0201, 1'b0);  // 5 bytes
        cycles(3);
        drain(257);
        cycles(3);
        chk(rdy_empty == 1'b1, "R7 all completions delivered", {63'b0, rdy_empty}, 64'h1);
        chk(exp_wr.size() == 0, "R2 all writes seen", 64'(exp_wr.size()), 64'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule